// File: doc/BRIEF.md
# Partition-Aware Eviction Way Picker

This block decides which way of a set-associative cache a fill should overwrite. The requester is either one of several processor cores or the shared class of hardware agents. Each request presents the valid, locked and use bits of every way in the indexed set. The block holds one blocking mask per core and one blocking mask shared by all hardware agents. A set bit in a mask keeps that requester from evicting from that way. Only eviction is restricted. Lookups that hit may use any way and never pass through this block.

First the candidate set is formed: the ways that the requester's mask allows and that are not locked. Within that set, an empty way wins. If there is none, a filled way whose use bit is clear wins. If every candidate is filled and recently used, the block returns a mask telling the tag array to clear those use bits, and it picks the lowest candidate. If no candidate is left, the block raises a no-victim flag so that the fill bypasses allocation. A mask write that would block every way is refused, and the stored mask stays as it was.

Top module: `evict_way_pick`

## Requirements
- R1: After reset every stored mask is zero, which allows all ways. `pick_vld` is low until a request is made.
- R2: `req_src` values 0 to CORES-1 select that core's own mask. The value CORES selects the single mask shared by the hardware agents. A write through `mcfg_sel` changes only the mask it selects.
- R3: A way whose bit is 1 in the requester's mask, sampled in the cycle of the request, is never returned as the victim.
- R4: A way whose `set_lock` bit is 1 is never returned as the victim.
- R5: A mask write whose value is all ones is refused, and the stored mask keeps its previous value. An `mcfg_sel` value above CORES is ignored.
- R6: If any candidate way (allowed and unlocked) has `set_valid`=0, the victim is the lowest-indexed such way and `use_clr` is zero.
- R7: If every candidate is valid and some have `set_use`=0, the victim is the lowest-indexed valid candidate with use 0, and `use_clr` is zero.
- R8: If every candidate is valid with use 1, `use_clr` equals the candidate set and the victim is the lowest-indexed candidate.
- R9: With no candidate left, `pick_none`=1, `pick_way`=0 and `use_clr`=0.
- R10: Results are registered. `pick_vld` is high exactly in the cycle after a cycle with `req_vld` high, and the other outputs belong to that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mcfg_we | input | 1 | Mask write strobe |
| mcfg_sel | input | SRC_W | Mask to write: core number, or CORES for the hardware agents |
| mcfg_mask | input | WAYS | New blocking mask (1 = eviction forbidden) |
| req_vld | input | 1 | Victim request strobe |
| req_src | input | SRC_W | Requester: core number, or CORES for a hardware agent |
| set_valid | input | WAYS | Valid bit of each way in the set |
| set_lock | input | WAYS | Locked bit of each way in the set |
| set_use | input | WAYS | Use bit of each way in the set |
| pick_vld | output | 1 | Result valid, one cycle after the request |
| pick_way | output | WAY_W | Victim way index |
| pick_none | output | 1 | No evictable way; bypass allocation |
| use_clr | output | WAYS | Use bits the tag array should clear |

## Verification
Directed sets cover each priority tier in isolation:
- A set with one empty way among used ones shows that empty ways win over the use bits.
- A fully valid set with mixed use bits shows the LRU tier.
- A set that is fully valid and fully used shows the use-bit clearing.
- A set whose allowed ways are all locked shows the no-victim path.

Two requesters are given different masks against identical line bits, which shows that each requester's mask is selected separately. An all-ones write followed by a request distinguishes a refused write from an accepted one. Random line bits, random requesters and random mask writes then mix all four tiers against a bench reference model.

// File: rtl/evict_way_pick.sv
module evict_way_pick #(
  parameter int WAYS  = 8,
  parameter int CORES = 4,
  localparam int SRCS  = CORES + 1,
  localparam int SRC_W = $clog2(SRCS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mcfg_we,
  input  logic [SRC_W-1:0] mcfg_sel,
  input  logic [WAYS-1:0]  mcfg_mask,
  input  logic             req_vld,
  input  logic [SRC_W-1:0] req_src,
  input  logic [WAYS-1:0]  set_valid,
  input  logic [WAYS-1:0]  set_lock,
  input  logic [WAYS-1:0]  set_use,
  output logic             pick_vld,
  output logic [WAY_W-1:0] pick_way,
  output logic             pick_none,
  output logic [WAYS-1:0]  use_clr
);

  logic [SRCS-1:0][WAYS-1:0] mask_q;

  function automatic logic [WAY_W-1:0] lowest(input logic [WAYS-1:0] v);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int i = WAYS - 1; i >= 0; i--)
      if (v[i]) r = WAY_W'(i);
    return r;
  endfunction

  wire             wr_ok    = mcfg_we && !(&mcfg_mask) && (int'(mcfg_sel) < SRCS);
  wire [WAYS-1:0]  src_mask = (int'(req_src) < SRCS) ? mask_q[req_src] : {WAYS{1'b1}};
  wire [WAYS-1:0]  cand     = ~src_mask & ~set_lock;
  wire [WAYS-1:0]  empty_c  = cand & ~set_valid;
  wire [WAYS-1:0]  cold_c   = cand & set_valid & ~set_use;

  logic [WAY_W-1:0] nxt_way;
  logic [WAYS-1:0]  nxt_clr;
  always_comb begin
    nxt_clr = '0;
    if (empty_c != '0)     nxt_way = lowest(empty_c);
    else if (cold_c != '0) nxt_way = lowest(cold_c);
    else begin
      nxt_way = lowest(cand);
      nxt_clr = cand;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q    <= '0;
      pick_vld  <= 1'b0;
      pick_way  <= '0;
      pick_none <= 1'b0;
      use_clr   <= '0;
    end else begin
      if (wr_ok) mask_q[mcfg_sel] <= mcfg_mask;
      pick_vld <= req_vld;
      if (req_vld) begin
        pick_none <= (cand == '0);
        pick_way  <= (cand == '0) ? '0 : nxt_way;
        use_clr   <= (cand == '0) ? '0 : nxt_clr;
      end
    end
  end

  a_r3_masked_never_picked: assert property (@(posedge clk) disable iff (!rst_n)
    pick_vld && !pick_none && $past(rst_n) |-> !(($past(src_mask) >> pick_way) & 1));
  a_r4_locked_never_picked: assert property (@(posedge clk) disable iff (!rst_n)
    pick_vld && !pick_none && $past(rst_n) |-> !(($past(set_lock) >> pick_way) & 1));
  a_r5_full_block_refused: assert property (@(posedge clk) disable iff (!rst_n)
    mcfg_we && (&mcfg_mask) |=> $stable(mask_q));
  a_r8_clear_covers_victim: assert property (@(posedge clk) disable iff (!rst_n)
    pick_vld && (use_clr != '0) |-> ((use_clr >> pick_way) & 1) && $past(&(set_use | ~cand)));
  a_r9_none_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    pick_vld && pick_none |-> use_clr == '0 && pick_way == '0);
  a_r10_one_cycle_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> pick_vld == $past(req_vld));

endmodule

// File: tb/evict_way_pick_tb_top.sv
`timescale 1ns/1ps
module evict_way_pick_tb_top;
  localparam int WAYS = 8, CORES = 4, SRCS = CORES + 1;
  localparam int SRC_W = $clog2(SRCS), WAY_W = $clog2(WAYS);

  logic clk = 0, rst_n = 0;
  logic mcfg_we = 0; logic [SRC_W-1:0] mcfg_sel = 0; logic [WAYS-1:0] mcfg_mask = 0;
  logic req_vld = 0; logic [SRC_W-1:0] req_src = 0;
  logic [WAYS-1:0] set_valid = 0, set_lock = 0, set_use = 0;
  logic pick_vld, pick_none; logic [WAY_W-1:0] pick_way; logic [WAYS-1:0] use_clr;

  int n_cmp = 0, n_bad = 0;
  logic [WAYS-1:0] mdl [SRCS];
  bit done = 0;

  always #2.5 clk = ~clk;

  evict_way_pick #(.WAYS(WAYS), .CORES(CORES)) dut_i (.*);

  function automatic int low(input logic [WAYS-1:0] v);
    for (int i = 0; i < WAYS; i++) if (v[i]) return i;
    return 0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int sel, input logic [WAYS-1:0] m);
    @(negedge clk);
    mcfg_we = 1; mcfg_sel = SRC_W'(sel); mcfg_mask = m;
    @(negedge clk);
    mcfg_we = 0;
    if (sel < SRCS && !(&m)) mdl[sel] = m;
  endtask

  task automatic rq(input int src, input logic [WAYS-1:0] v, input logic [WAYS-1:0] l,
                    input logic [WAYS-1:0] u);
    logic [WAYS-1:0] cand, clr; int way; bit none; string tag;
    @(negedge clk);
    req_vld = 1; req_src = SRC_W'(src); set_valid = v; set_lock = l; set_use = u;
    cand = ~mdl[src] & ~l; clr = 0; none = 0; way = 0;
    if (cand == 0) begin none = 1; tag = "R9"; end
    else if ((cand & ~v) != 0) begin way = low(cand & ~v); tag = "R6"; end
    else if ((cand & v & ~u) != 0) begin way = low(cand & v & ~u); tag = "R7"; end
    else begin way = low(cand); clr = cand; tag = "R8"; end
    @(negedge clk);
    req_vld = 0;
    chk("R10 valid", 32'(pick_vld), 1);
    chk({tag, " none"}, 32'(pick_none), 32'(none));
    chk({tag, " way"}, 32'(pick_way), 32'(way));
    chk({tag, " clr"}, 32'(use_clr), 32'(clr));
    if (!none) begin
      chk("R3 mask", 32'(mdl[src][pick_way]), 0);
      chk("R4 lock", 32'(l[pick_way]), 0);
    end
  endtask

  initial begin
    for (int i = 0; i < SRCS; i++) mdl[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle", 32'(pick_vld), 0);
    rq(0, 8'hFF, 8'h00, 8'hFE);            // R1: all allowed, way 0 cold
    rq(2, 8'hFF, 8'h00, 8'hFF);            // R8: everything used
    rq(1, 8'hF7, 8'h01, 8'hFF);            // R6: way 3 empty
    rq(3, 8'hFF, 8'h00, 8'h5F);            // R7: way 5 cold
    wr(0, 8'h0F);                          // R2: core 0 only
    rq(0, 8'hFF, 8'h00, 8'h00);            // R3: expect way 4
    rq(1, 8'hFF, 8'h00, 8'h00);            // R2: core 1 untouched, way 0
    wr(CORES, 8'hF0);                      // R2: hw agents
    rq(CORES, 8'hFF, 8'h00, 8'hFF);        // R8 on hw mask, ways 0..3
    wr(CORES, 8'hFF);                      // R5: refused
    rq(CORES, 8'hFF, 8'h00, 8'hFF);
    wr(7, 8'h00);                          // R5: out-of-range select ignored
    rq(0, 8'hFF, 8'hF0, 8'h00);            // R9: allowed ways all locked
    rq(0, 8'hFF, 8'h30, 8'hFF);            // R4: lowest unlocked is way 6
    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(0, 9) == 0) begin
        logic [WAYS-1:0] m;
        m = ($urandom_range(0, 4) == 0) ? 8'hFF : WAYS'($urandom);
        wr($urandom_range(0, SRCS), m);
      end
      rq($urandom_range(0, CORES), WAYS'($urandom | $urandom), WAYS'($urandom & $urandom),
         WAYS'($urandom | $urandom));
    end
    @(negedge clk);
    chk("R10 idle", 32'(pick_vld), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule